// File: doc/BRIEF.md
# Serial Port Register File with Interrupt Identification

This block is the processor-facing register set of a classic byte-wide serial port. A small byte bus (address, write strobe, read strobe, write data and combinational read data) selects one of eight locations. Behind them sit the receive buffer, the transmit holding register, the interrupt enable and identification registers, the line and modem control registers, the line and modem status registers, a scratch byte and a 16-bit baud divisor. The divisor shares the two lowest locations with the data and enable registers and is reached through a select bit in the line control register.

On the line side, a receiver presents bytes or a break event. The block holds one received byte and refuses further bytes until software reads it. A written transmit byte is offered on a valid/take pair. Modem input pins are sampled into the modem status register. A loopback mode reflects the modem control outputs back into that register. The line control register is also presented in decoded form: word length, stop bits, parity and break. The interrupt output is a registered level that follows a two-source priority scheme. Received data ranks above transmit-empty. The transmit-empty source is a hidden flag that is cleared by reading the identification register.

Top module: `uart_regbank`

## Requirements
- R1: The location is `bus_addr[2:0]` and higher address bits are ignored. Offset 7 is a scratch byte that returns any written value. Writes to offsets 2, 5 and 6 change no state.
- R2: While line control bit 7 is set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. `divisor_o` always shows the stored divisor.
- R3: A data write at offset 0 with bit 7 clear captures the byte on `tx_data_o`, raises `tx_valid_o`, and clears the pending flag and line status bit 5. On the cycle `tx_take_i` meets `tx_valid_o`, the valid drops and line status bits 5 and 6 and the pending flag are set.
- R4: An interrupt enable write keeps only bits 3:0, and reads return 0 above them. If line status bit 5 is set when the write occurs, the transmit pending flag is set.
- R5: The identification register (offset 2) reads 0x04 when line status bit 0 and enable bit 0 are both set. Otherwise it reads 0x02 when the pending flag and enable bit 1 are both set. Otherwise it reads 0x01.
- R6: Reading offset 2 while it shows 0x02 clears the pending flag. A following read shows the re-evaluated value.
- R7: A byte on `rx_byte_i` with `rx_valid_i` is stored only while line status bit 0 is clear, and that bit is then set. `rx_ready_o` is the inverse of line status bit 0.
- R8: `rx_break_i` loads 0x00 into the receive buffer and sets line status bits 4 and 0. Reading the receive buffer (offset 0, bit 7 of line control clear) clears bits 4 and 0.
- R9: Modem control writes keep bits 4:0. `dtr_o`, `rts_o`, `aux1_o` and `aux2_o` show bits 0, 1, 2 and 3.
- R10: With modem control bit 4 set, offset 6 reads bit 3 on bit 7, bit 2 on bit 6, bit 0 on bit 5 and bit 1 on bit 4, with zeros below. With bit 4 clear, it reads the pins sampled on the previous clock as {dcd, ri, dsr, cts, 0000}.
- R11: After reset, line status reads 0x60, identification reads 0x01, modem status reads 0xB0, and `irq_o` is low.
- R12: The line control bits are decoded as follows: `data_bits_o` = bits 1:0 plus 5, `two_stop_o` = bit 2, `parity_en_o` = bit 3, `parity_even_o` = bit 4 and `break_o` = bit 6.
- R13: `irq_o` is high in the cycle after any cycle in which the identification value is not 0x01, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register location; only bits 2:0 decoded |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; triggers read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed location (combinational) |
| irq_o | output | 1 | Registered interrupt level |
| rx_valid_i | input | 1 | Received byte offered |
| rx_byte_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Break condition received |
| rx_ready_o | output | 1 | Receive buffer can take a byte |
| tx_take_i | input | 1 | Line side accepts the transmit byte |
| tx_valid_o | output | 1 | Transmit byte waiting |
| tx_data_o | output | 8 | Transmit byte |
| dcd_i | input | 1 | Carrier detect pin |
| ri_i | input | 1 | Ring indicator pin |
| dsr_i | input | 1 | Data set ready pin |
| cts_i | input | 1 | Clear to send pin |
| dtr_o | output | 1 | Modem control bit 0 |
| rts_o | output | 1 | Modem control bit 1 |
| aux1_o | output | 1 | Modem control bit 2 |
| aux2_o | output | 1 | Modem control bit 3 |
| divisor_o | output | 16 | Baud divisor |
| data_bits_o | output | 4 | Word length, 5 to 8 |
| two_stop_o | output | 1 | Two stop bits selected |
| parity_en_o | output | 1 | Parity enabled |
| parity_even_o | output | 1 | Even parity selected |
| break_o | output | 1 | Break control |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that a strobe lasts exactly one cycle per access. Without these, the side effects of a receive buffer or identification read and a write would overlap in ways the requirements do not order. The random stimulus draws one bus operation per cycle, either a read, a write or idle, so both strobes are never raised together. Receive, break, take and modem pin activity are drawn independently of the bus. Same-cycle collisions such as a take together with a pending-clearing read therefore do occur.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    localparam int BYTE_W = 8;
    localparam int DIV_W  = 2 * BYTE_W;
    localparam int OFS_W  = 3;

    localparam logic [OFS_W-1:0] LOC_DATA  = 3'd0;
    localparam logic [OFS_W-1:0] LOC_IEN   = 3'd1;
    localparam logic [OFS_W-1:0] LOC_IID   = 3'd2;
    localparam logic [OFS_W-1:0] LOC_LCTL  = 3'd3;
    localparam logic [OFS_W-1:0] LOC_MCTL  = 3'd4;
    localparam logic [OFS_W-1:0] LOC_LSTAT = 3'd5;
    localparam logic [OFS_W-1:0] LOC_MSTAT = 3'd6;
    localparam logic [OFS_W-1:0] LOC_SCR   = 3'd7;

    localparam int LCTL_DIVSEL = 7;
    localparam int MCTL_LOOP   = 4;

    localparam logic [BYTE_W-1:0] IID_NONE = 8'h01;
    localparam logic [BYTE_W-1:0] IID_TX   = 8'h02;
    localparam logic [BYTE_W-1:0] IID_RX   = 8'h04;

    localparam logic [BYTE_W-1:0] MSTAT_RST = 8'hB0;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       brk;
    } line_cfg_t;

    typedef struct packed {
        logic rdy;
        logic brk;
        logic hold_empty;
        logic all_empty;
    } line_stat_t;

    function automatic line_cfg_t decode_line(input logic [BYTE_W-1:0] lc);
        line_cfg_t c;
        c.data_bits = 4'd5 + {2'b00, lc[1:0]};
        c.two_stop  = lc[2];
        c.par_en    = lc[3];
        c.par_even  = lc[4];
        c.brk       = lc[6];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_lstat(input line_stat_t s);
        return {1'b0, s.all_empty, s.hold_empty, s.brk, 3'b000, s.rdy};
    endfunction

    function automatic logic [BYTE_W-1:0] loop_status(input logic [BYTE_W-1:0] mc);
        return {mc[3], mc[2], mc[0], mc[1], 4'b0000};
    endfunction

endpackage

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
    import uart_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_ready,
    input  logic              rx_en,
    input  logic              tx_pend,
    input  logic              tx_en,
    output logic [BYTE_W-1:0] iid_code,
    output logic              irq_o
);

    always_comb begin
        if (data_ready && rx_en)
            iid_code = IID_RX;
        else if (tx_pend && tx_en)
            iid_code = IID_TX;
        else
            iid_code = IID_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else
            irq_o <= (iid_code != IID_NONE);
    end

    // R13
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(iid_code != IID_NONE)));

    // R5
    iid_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(iid_code) == 1);

endmodule

// File: rtl/uart_rb_modem.sv
module uart_rb_modem
    import uart_rb_pkg::*;
#(
    parameter int MCR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dcd_i,
    input  logic              ri_i,
    input  logic              dsr_i,
    input  logic              cts_i,
    input  logic [MCR_W-1:0]  mctl,
    output logic [BYTE_W-1:0] status_o
);

    logic [BYTE_W-1:0] pins_q;
    logic [BYTE_W-1:0] mctl_b;

    always_ff @(posedge clk) begin
        if (rst)
            pins_q <= MSTAT_RST;
        else
            pins_q <= {dcd_i, ri_i, dsr_i, cts_i, 4'b0000};
    end

    always_comb begin
        mctl_b = '0;
        mctl_b[MCR_W-1:0] = mctl;
        status_o = mctl_b[MCTL_LOOP] ? loop_status(mctl_b) : pins_q;
    end

    // R10
    pin_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !mctl_b[MCTL_LOOP]) |->
        (status_o == {$past(dcd_i), $past(ri_i), $past(dsr_i), $past(cts_i), 4'b0000}));

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int IER_W  = 4,
    parameter int MCR_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq_o,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              rx_break_i,
    output logic              rx_ready_o,
    input  logic              tx_take_i,
    output logic              tx_valid_o,
    output logic [BYTE_W-1:0] tx_data_o,
    input  logic              dcd_i,
    input  logic              ri_i,
    input  logic              dsr_i,
    input  logic              cts_i,
    output logic              dtr_o,
    output logic              rts_o,
    output logic              aux1_o,
    output logic              aux2_o,
    output logic [DIV_W-1:0]  divisor_o,
    output logic [3:0]        data_bits_o,
    output logic              two_stop_o,
    output logic              parity_en_o,
    output logic              parity_even_o,
    output logic              break_o
);

    localparam int HALF = DIV_W / 2;

    logic [OFS_W-1:0]  loc;
    logic [BYTE_W-1:0] rbuf_q, lctl_q, scr_q, txd_q;
    logic [IER_W-1:0]  ien_q;
    logic [MCR_W-1:0]  mctl_q;
    logic [DIV_W-1:0]  div_q;
    line_stat_t        lst_q;
    logic              pend_q, txv_q;
    logic [BYTE_W-1:0] iid_code, mstat, ien_b, mctl_b;
    line_cfg_t         cfg;

    assign loc = bus_addr[OFS_W-1:0];

    generate
        if (ADDR_W > OFS_W) begin : g_hi_addr
            logic addr_unused;
            assign addr_unused = ^bus_addr[ADDR_W-1:OFS_W];
        end
    endgenerate

    logic divsel, wr_thr, wr_ien, rd_rbuf, rd_iid, tx_done, rx_acc;
    assign divsel  = lctl_q[LCTL_DIVSEL];
    assign wr_thr  = bus_wr && (loc == LOC_DATA) && !divsel;
    assign wr_ien  = bus_wr && (loc == LOC_IEN) && !divsel;
    assign rd_rbuf = bus_rd && (loc == LOC_DATA) && !divsel;
    assign rd_iid  = bus_rd && (loc == LOC_IID);
    assign tx_done = txv_q && tx_take_i;
    assign rx_acc  = rx_valid_i && !lst_q.rdy;

    // line status, receive buffer, transmit handoff, pending flag
    always_ff @(posedge clk) begin
        if (rst) begin
            lst_q  <= '{rdy: 1'b0, brk: 1'b0, hold_empty: 1'b1, all_empty: 1'b1};
            pend_q <= 1'b0;
            txv_q  <= 1'b0;
            txd_q  <= '0;
            rbuf_q <= '0;
        end else begin
            if (tx_done) begin
                lst_q.hold_empty <= 1'b1;
                lst_q.all_empty  <= 1'b1;
                pend_q           <= 1'b1;
                txv_q            <= 1'b0;
            end
            if (wr_thr) begin
                txd_q            <= bus_wdata;
                txv_q            <= 1'b1;
                lst_q.hold_empty <= 1'b0;
                pend_q           <= 1'b0;
            end
            if (wr_ien && lst_q.hold_empty)
                pend_q <= 1'b1;
            if (rd_iid && (iid_code == IID_TX))
                pend_q <= 1'b0;
            if (rd_rbuf) begin
                lst_q.rdy <= 1'b0;
                lst_q.brk <= 1'b0;
            end
            if (rx_break_i) begin
                rbuf_q    <= '0;
                lst_q.brk <= 1'b1;
                lst_q.rdy <= 1'b1;
            end else if (rx_acc) begin
                rbuf_q    <= rx_byte_i;
                lst_q.rdy <= 1'b1;
            end
        end
    end

    // plain configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            lctl_q <= '0;
            mctl_q <= '0;
            scr_q  <= '0;
            div_q  <= '0;
        end else if (bus_wr) begin
            unique case (loc)
                LOC_DATA:  if (divsel) div_q[HALF-1:0] <= bus_wdata;
                LOC_IEN:   if (divsel) div_q[DIV_W-1:HALF] <= bus_wdata;
                           else        ien_q <= bus_wdata[IER_W-1:0];
                LOC_LCTL:  lctl_q <= bus_wdata;
                LOC_MCTL:  mctl_q <= bus_wdata[MCR_W-1:0];
                LOC_SCR:   scr_q  <= bus_wdata;
                default:   ;
            endcase
        end
    end

    uart_rb_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .data_ready (lst_q.rdy),
        .rx_en      (ien_q[0]),
        .tx_pend    (pend_q),
        .tx_en      (ien_q[1]),
        .iid_code   (iid_code),
        .irq_o      (irq_o)
    );

    uart_rb_modem #(.MCR_W(MCR_W)) u_modem (
        .clk      (clk),
        .rst      (rst),
        .dcd_i    (dcd_i),
        .ri_i     (ri_i),
        .dsr_i    (dsr_i),
        .cts_i    (cts_i),
        .mctl     (mctl_q),
        .status_o (mstat)
    );

    always_comb begin
        ien_b  = '0;
        ien_b[IER_W-1:0] = ien_q;
        mctl_b = '0;
        mctl_b[MCR_W-1:0] = mctl_q;
        unique case (loc)
            LOC_DATA:  bus_rdata = divsel ? div_q[HALF-1:0] : rbuf_q;
            LOC_IEN:   bus_rdata = divsel ? div_q[DIV_W-1:HALF] : ien_b;
            LOC_IID:   bus_rdata = iid_code;
            LOC_LCTL:  bus_rdata = lctl_q;
            LOC_MCTL:  bus_rdata = mctl_b;
            LOC_LSTAT: bus_rdata = pack_lstat(lst_q);
            LOC_MSTAT: bus_rdata = mstat;
            default:   bus_rdata = scr_q;
        endcase
    end

    assign cfg           = decode_line(lctl_q);
    assign data_bits_o   = cfg.data_bits;
    assign two_stop_o    = cfg.two_stop;
    assign parity_en_o   = cfg.par_en;
    assign parity_even_o = cfg.par_even;
    assign break_o       = cfg.brk;
    assign divisor_o     = div_q;
    assign rx_ready_o    = !lst_q.rdy;
    assign tx_valid_o    = txv_q;
    assign tx_data_o     = txd_q;
    assign dtr_o         = mctl_q[0];
    assign rts_o         = mctl_q[1];
    assign aux1_o        = mctl_q[2];
    assign aux2_o        = mctl_q[3];

    // R3
    thr_handoff_chk: assert property (@(posedge clk) disable iff (rst)
        wr_thr |=> (tx_valid_o && tx_data_o == $past(bus_wdata) && !bus_rdata_hold_empty()));

    function automatic logic bus_rdata_hold_empty();
        return lst_q.hold_empty;
    endfunction

    // R7
    rx_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_i && rx_ready_o && !rx_break_i) |=> (!rx_ready_o && rbuf_q == $past(rx_byte_i)));

    // R8
    rbuf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rbuf && !rx_break_i && !(rx_valid_i && rx_ready_o)) |=> (rx_ready_o && !lst_q.brk));

    // R6
    iid_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_iid && iid_code == IID_TX && !tx_take_i) |=> !pend_q);

    // R4
    ien_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ien && lst_q.hold_empty) |=> pend_q);

endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_o;
    logic        rx_valid_i = 1'b0, rx_break_i = 1'b0, tx_take_i = 1'b0;
    logic [7:0]  rx_byte_i = '0;
    logic        rx_ready_o, tx_valid_o;
    logic [7:0]  tx_data_o;
    logic        dcd_i = 1'b1, ri_i = 1'b0, dsr_i = 1'b1, cts_i = 1'b1;
    logic        dtr_o, rts_o, aux1_o, aux2_o;
    logic [15:0] divisor_o;
    logic [3:0]  data_bits_o;
    logic        two_stop_o, parity_en_o, parity_even_o, break_o;

    always #4 clk = ~clk;

    uart_regbank dut_i (.*);

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference model
    logic [7:0]  m_rbuf, m_lctl, m_scr, m_txd, m_mstat;
    logic [3:0]  m_ien;
    logic [4:0]  m_mctl;
    logic [15:0] m_div;
    logic        m_rdy, m_brk, m_thre, m_temt, m_pend, m_txv, exp_irq;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_iid();
        if (m_rdy && m_ien[0]) return 8'h04;
        if (m_pend && m_ien[1]) return 8'h02;
        return 8'h01;
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_lctl[7] ? m_div[7:0] : m_rbuf;
            3'd1: return m_lctl[7] ? m_div[15:8] : {4'b0, m_ien};
            3'd2: return m_iid();
            3'd3: return m_lctl;
            3'd4: return {3'b0, m_mctl};
            3'd5: return {1'b0, m_temt, m_thre, m_brk, 3'b0, m_rdy};
            3'd6: return m_mctl[4] ? {m_mctl[3], m_mctl[2], m_mctl[0], m_mctl[1], 4'b0} : m_mstat;
            default: return m_scr;
        endcase
    endfunction

    function automatic string rtag(input logic [2:0] a);
        case (a)
            3'd0: return m_lctl[7] ? "R2 read div lo" : "R7 read rbuf";
            3'd1: return m_lctl[7] ? "R2 read div hi" : "R4 read ien";
            3'd2: return "R5 read iid";
            3'd3: return "R12 read lctl";
            3'd4: return "R9 read mctl";
            3'd5: return "R3 read lstat";
            3'd6: return "R10 read mstat";
            default: return "R1 read scratch";
        endcase
    endfunction

    task automatic cyc(input logic [3:0] a, input logic w, input logic r, input logic [7:0] d,
                       input logic rv, input logic [7:0] rb, input logic bk, input logic tk,
                       input string tag);
        logic [7:0] o_iid;
        logic o_rdy, o_thre, nxt_irq;
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        rx_valid_i = rv; rx_byte_i = rb; rx_break_i = bk; tx_take_i = tk;
        #1;
        chk("R13 irq level", irq_o, exp_irq);
        chk("R7 rx_ready", rx_ready_o, !m_rdy);
        chk("R3 tx_valid", tx_valid_o, m_txv);
        if (m_txv) chk("R3 tx_data", tx_data_o, m_txd);
        chk("R2 divisor", divisor_o, m_div);
        chk("R12 line decode", {data_bits_o, two_stop_o, parity_en_o, parity_even_o, break_o},
            {4'd5 + {2'b0, m_lctl[1:0]}, m_lctl[2], m_lctl[3], m_lctl[4], m_lctl[6]});
        chk("R9 modem pins", {aux2_o, aux1_o, rts_o, dtr_o}, m_mctl[3:0]);
        if (r) chk(tag == "" ? rtag(a[2:0]) : tag, bus_rdata, m_read(a[2:0]));
        nxt_irq = (m_iid() != 8'h01);
        o_iid = m_iid(); o_rdy = m_rdy; o_thre = m_thre;
        if (tk && m_txv) begin m_thre = 1; m_temt = 1; m_pend = 1; m_txv = 0; end
        if (w) begin
            case (a[2:0])
                3'd0: if (m_lctl[7]) m_div[7:0] = d;
                      else begin m_txd = d; m_txv = 1; m_thre = 0; m_pend = 0; end
                3'd1: if (m_lctl[7]) m_div[15:8] = d;
                      else begin m_ien = d[3:0]; if (o_thre) m_pend = 1; end
                3'd3: m_lctl = d;
                3'd4: m_mctl = d[4:0];
                3'd7: m_scr = d;
                default: ;
            endcase
        end
        if (r) begin
            if (a[2:0] == 3'd0 && !m_lctl[7]) begin m_rdy = 0; m_brk = 0; end
            if (a[2:0] == 3'd2 && o_iid == 8'h02) m_pend = 0;
        end
        if (bk) begin m_rbuf = 8'h00; m_brk = 1; m_rdy = 1; end
        else if (rv && !o_rdy) begin m_rbuf = rb; m_rdy = 1; end
        @(posedge clk);
        m_mstat = {dcd_i, ri_i, dsr_i, cts_i, 4'b0};
        exp_irq = nxt_irq;
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, input string tag = "");
        cyc(a, 0, 1, 8'h00, 0, 8'h00, 0, 0, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(a, 1, 0, d, 0, 8'h00, 0, 0, "");
    endtask

    initial begin
        m_rbuf = 0; m_lctl = 0; m_scr = 0; m_txd = 0; m_mstat = 8'hB0;
        m_ien = 0; m_mctl = 0; m_div = 0;
        m_rdy = 0; m_brk = 0; m_thre = 1; m_temt = 1; m_pend = 0; m_txv = 0; exp_irq = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        rd(4'd5, "R11 reset lstat");
        chk("R11 reset lstat value", bus_rdata, 8'h60);
        rd(4'd2, "R11 reset iid");
        rd(4'd6, "R11 reset mstat");
        chk("R11 irq after reset", irq_o, 1'b0);
        // R1 scratch, aliasing and ignored writes
        wr(4'd7, 8'hA5);
        rd(4'd15, "R1 scratch via alias");
        wr(4'd2, 8'hFF); wr(4'd5, 8'h00); wr(4'd6, 8'h00);
        rd(4'd5, "R1 lstat after ignored writes");
        rd(4'd2, "R1 iid after ignored writes");
        // R2 divisor
        wr(4'd3, 8'h83); wr(4'd0, 8'h34); wr(4'd1, 8'h12);
        rd(4'd0, "R2 div lo"); rd(4'd1, "R2 div hi");
        wr(4'd3, 8'h03);
        // R4, R5, R6 transmit pending
        wr(4'd1, 8'hFF);
        rd(4'd1, "R4 ien masked");
        rd(4'd2, "R5 iid tx");
        rd(4'd2, "R6 iid after clear");
        // R3 transmit handoff
        wr(4'd0, 8'h5A);
        rd(4'd5, "R3 lstat while busy");
        cyc(4'd0, 0, 0, 8'h00, 0, 8'h00, 0, 1, "");
        rd(4'd5, "R3 lstat after take");
        rd(4'd2, "R6 iid tx again");
        // R7 receive, priority, reject when full
        cyc(4'd0, 0, 0, 8'h00, 1, 8'h77, 0, 0, "");
        cyc(4'd0, 0, 0, 8'h00, 1, 8'h11, 0, 0, "");
        rd(4'd2, "R5 rx beats tx");
        rd(4'd0, "R7 first byte kept");
        // R8 break
        cyc(4'd0, 0, 0, 8'h00, 0, 8'h00, 1, 0, "");
        rd(4'd5, "R8 lstat break");
        rd(4'd0, "R8 break byte");
        rd(4'd5, "R8 lstat cleared");
        // R9, R10 modem control and loopback
        wr(4'd4, 8'hFF); rd(4'd4, "R9 mctl masked"); rd(4'd6, "R10 loop all");
        wr(4'd4, 8'h15); rd(4'd6, "R10 loop dtr out1");
        dcd_i = 0; ri_i = 1; dsr_i = 0; cts_i = 1;
        wr(4'd4, 8'h0A); rd(4'd6, "R10 pins sampled");
        // R12 line decode
        wr(4'd3, 8'h5E); rd(4'd3, "R12 lctl");
        // random phase
        void'($urandom(32'd4242));
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [3:0] a;
            op = $urandom % 8;
            a = 4'($urandom);
            {dcd_i, ri_i, dsr_i, cts_i} = 4'($urandom);
            cyc(a, op inside {[3:4]}, op inside {[0:2]}, 8'($urandom),
                ($urandom % 4) == 0, 8'($urandom), ($urandom % 32) == 0,
                ($urandom % 3) == 0, "");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R13 watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule